// File: doc/BRIEF.md
# Banked Level Interrupt Controller with Pending Summary

This block collects 72 level-sensitive interrupt sources and presents them to a processor through a small word-addressed register window. The sources are split into a low wide bank (numbers 0 to 31), a high wide bank (32 to 63) and a short basic bank (64 to 71). Each source has one enable bit. Software turns enables on through write-one-to-set addresses and off through separate write-one-to-clear addresses, so no read-modify-write is needed.

A source is pending while its input is high and it is enabled. Software first reads a summary word. That word holds the basic bank's pending bits and one flag for each wide bank. It then reads the pending word of the flagged bank. The block also resolves the next interrupt to serve in hardware. A basic source wins over the wide banks, and the low bank wins over the high bank. Inside a group, the lowest set bit wins. The block drives a request line, the resolved source number and a valid flag, all registered. The window also holds a 32-bit fast-interrupt control word, which the block only stores.

Top module: `irq_bank_ctrl`

## Requirements
- R1: A source is pending when its input is high and its enable is set. Word 1 reads the pending bits of sources 0..31 and word 2 those of sources 32..63. Word 0 reads bits 7:0 = pending sources 64..71, bit 8 = OR of the low-bank pending bits, bit 9 = OR of the high-bank pending bits, and zeros above.
- R2: A write to word 4 (low bank), 5 (high bank) or 6 (basic bank, bits 7:0) sets every enable whose data bit is one. All other enables keep their value.
- R3: A write to word 7 (low bank), 8 (high bank) or 9 (basic bank, bits 7:0) clears every enable whose data bit is one. All other enables keep their value.
- R4: Reading words 4 and 7 returns the low-bank enable mask. Words 5 and 8 return the high-bank mask. Words 6 and 9 return the basic mask in bits 7:0, with zeros in bits 31:8.
- R5: When anything is pending, `irq_num_o` gives the source to serve. Any pending basic source is chosen before the low bank, and the low bank before the high bank. Within the chosen group the lowest index wins, and the number is the group base (64, 0 or 32) plus that index.
- R6: When nothing is pending, `irq_valid_o` is low and `irq_num_o` is zero.
- R7: `irq_o` is high one cycle after any source is pending. It falls one cycle after the last pending source drops or is disabled.
- R8: Writes to words 0, 1 and 2 are ignored, and no enable changes.
- R9: Word 3 is a read/write 32-bit storage register that resets to zero.
- R10: After reset all enables are zero, and `irq_o`, `irq_valid_o`, `irq_num_o` and `bus_rdata_o` are zero.
- R11: A read (`bus_sel_i` high, `bus_we_i` low) puts the addressed word on `bus_rdata_o` after the next clock edge. The value then holds until the next read. Words 10..15 read as zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 72 | Source levels, bit n is source n |
| bus_sel_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt request |
| irq_num_o | output | 7 | Resolved source number |
| irq_valid_o | output | 1 | Resolved number is meaningful |

## Verification
The properties assume that the source levels are already synchronous to `clk` and never unknown after reset. They also assume the bus makes at most one access per cycle, so a set and a clear of the same bank can never land on the same edge. The bench changes sources and bus signals only on the falling edge, and it issues a single access per cycle through its tasks. Its random phase draws the source pattern, the address, the direction and the data independently each cycle. Every bank, every address including the unmapped ones, and overlapping basic/low/high pending patterns are therefore exercised within those assumptions.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int REG_ADDR_W = 4;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_SUMMARY   = 4'd0,
        REG_PEND_LO   = 4'd1,
        REG_PEND_HI   = 4'd2,
        REG_FAST_CTL  = 4'd3,
        REG_SET_LO    = 4'd4,
        REG_SET_HI    = 4'd5,
        REG_SET_BASIC = 4'd6,
        REG_CLR_LO    = 4'd7,
        REG_CLR_HI    = 4'd8,
        REG_CLR_BASIC = 4'd9
    } reg_addr_e;
endpackage

// File: rtl/irq_enable_regs.sv
module irq_enable_regs
    import irq_bank_pkg::*;
#(
    parameter int WIDE_W  = 32,
    parameter int BASIC_W = 8,
    parameter int DATA_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [WIDE_W-1:0]     en_lo,
    output logic [WIDE_W-1:0]     en_hi,
    output logic [BASIC_W-1:0]    en_basic,
    output logic [DATA_W-1:0]     fast_ctl
);
    typedef struct packed {
        logic [WIDE_W-1:0]  lo;
        logic [WIDE_W-1:0]  hi;
        logic [BASIC_W-1:0] basic;
        logic [DATA_W-1:0]  fast;
    } en_state_t;

    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                REG_SET_LO:    st_d.lo    = st_q.lo | wdata[WIDE_W-1:0];
                REG_SET_HI:    st_d.hi    = st_q.hi | wdata[WIDE_W-1:0];
                REG_SET_BASIC: st_d.basic = st_q.basic | wdata[BASIC_W-1:0];
                REG_CLR_LO:    st_d.lo    = st_q.lo & ~wdata[WIDE_W-1:0];
                REG_CLR_HI:    st_d.hi    = st_q.hi & ~wdata[WIDE_W-1:0];
                REG_CLR_BASIC: st_d.basic = st_q.basic & ~wdata[BASIC_W-1:0];
                REG_FAST_CTL:  st_d.fast  = wdata;
                default:       st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_lo    = st_q.lo;
    assign en_hi    = st_q.hi;
    assign en_basic = st_q.basic;
    assign fast_ctl = st_q.fast;
endmodule

// File: rtl/irq_first_set.sv
module irq_first_set #(
    parameter int W     = 32,
    parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign found = |vec;
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
    import irq_bank_pkg::*;
#(
    parameter int WIDE_W  = 32,
    parameter int BASIC_W = 8,
    parameter int DATA_W  = 32,
    localparam int NSRC       = 2 * WIDE_W + BASIC_W,
    localparam int NUM_W      = $clog2(NSRC),
    localparam int HI_BASE    = WIDE_W,
    localparam int BASIC_BASE = 2 * WIDE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NSRC-1:0]       irq_src_i,
    input  logic                  bus_sel_i,
    input  logic                  bus_we_i,
    input  logic [REG_ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0]     bus_wdata_i,
    output logic [DATA_W-1:0]     bus_rdata_o,
    output logic                  irq_o,
    output logic [NUM_W-1:0]      irq_num_o,
    output logic                  irq_valid_o
);
    localparam int WIDX_W = $clog2(WIDE_W);
    localparam int BIDX_W = (BASIC_W > 1) ? $clog2(BASIC_W) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              irq;
        logic [NUM_W-1:0]  num;
        logic              valid;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [WIDE_W-1:0]  en_lo, en_hi;
    logic [BASIC_W-1:0] en_basic;
    logic [DATA_W-1:0]  fast_ctl;
    logic [WIDE_W-1:0]  pend_lo, pend_hi;
    logic [BASIC_W-1:0] pend_basic;
    logic               f_lo, f_hi, f_basic;
    logic [WIDX_W-1:0]  idx_lo, idx_hi;
    logic [BIDX_W-1:0]  idx_basic;
    logic [DATA_W-1:0]  summary_word, rd_word;

    irq_enable_regs #(
        .WIDE_W (WIDE_W),
        .BASIC_W(BASIC_W),
        .DATA_W (DATA_W)
    ) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_sel_i & bus_we_i),
        .addr    (bus_addr_i),
        .wdata   (bus_wdata_i),
        .en_lo   (en_lo),
        .en_hi   (en_hi),
        .en_basic(en_basic),
        .fast_ctl(fast_ctl)
    );

    assign pend_lo    = irq_src_i[WIDE_W-1:0] & en_lo;
    assign pend_hi    = irq_src_i[2*WIDE_W-1:WIDE_W] & en_hi;
    assign pend_basic = irq_src_i[NSRC-1:BASIC_BASE] & en_basic;

    irq_first_set #(.W(WIDE_W), .IDX_W(WIDX_W)) u_pick_lo (
        .vec(pend_lo), .found(f_lo), .idx(idx_lo)
    );
    irq_first_set #(.W(WIDE_W), .IDX_W(WIDX_W)) u_pick_hi (
        .vec(pend_hi), .found(f_hi), .idx(idx_hi)
    );
    irq_first_set #(.W(BASIC_W), .IDX_W(BIDX_W)) u_pick_basic (
        .vec(pend_basic), .found(f_basic), .idx(idx_basic)
    );

    assign summary_word = DATA_W'({(pend_hi != '0), (pend_lo != '0), pend_basic});

    always_comb begin
        case (reg_addr_e'(bus_addr_i))
            REG_SUMMARY:                rd_word = summary_word;
            REG_PEND_LO:                rd_word = DATA_W'(pend_lo);
            REG_PEND_HI:                rd_word = DATA_W'(pend_hi);
            REG_FAST_CTL:               rd_word = fast_ctl;
            REG_SET_LO, REG_CLR_LO:     rd_word = DATA_W'(en_lo);
            REG_SET_HI, REG_CLR_HI:     rd_word = DATA_W'(en_hi);
            REG_SET_BASIC, REG_CLR_BASIC: rd_word = DATA_W'(en_basic);
            default:                    rd_word = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (bus_sel_i && !bus_we_i) begin
            st_d.rdata = rd_word;
        end
        st_d.irq = (|pend_lo) | (|pend_hi) | (|pend_basic);
        if (f_basic) begin
            st_d.valid = 1'b1;
            st_d.num   = NUM_W'(BASIC_BASE) + NUM_W'(idx_basic);
        end else if (f_lo) begin
            st_d.valid = 1'b1;
            st_d.num   = NUM_W'(idx_lo);
        end else if (f_hi) begin
            st_d.valid = 1'b1;
            st_d.num   = NUM_W'(HI_BASE) + NUM_W'(idx_hi);
        end else begin
            st_d.valid = 1'b0;
            st_d.num   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;
    assign irq_o       = st_q.irq;
    assign irq_num_o   = st_q.num;
    assign irq_valid_o = st_q.valid;
endmodule

// File: rtl/irq_bank_ctrl_chk.sv
module irq_bank_ctrl_chk
    import irq_bank_pkg::*;
#(
    parameter int WIDE_W  = 32,
    parameter int BASIC_W = 8,
    parameter int DATA_W  = 32,
    parameter int NSRC    = 72,
    parameter int NUM_W   = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NSRC-1:0]       src,
    input logic                  sel,
    input logic                  we,
    input logic [REG_ADDR_W-1:0] addr,
    input logic [DATA_W-1:0]     wdata,
    input logic [WIDE_W-1:0]     en_lo,
    input logic [WIDE_W-1:0]     en_hi,
    input logic [BASIC_W-1:0]    en_basic,
    input logic                  irq,
    input logic [NUM_W-1:0]      num,
    input logic                  valid
);
    logic any_lo, any_hi, any_basic;
    assign any_lo    = |(src[WIDE_W-1:0] & en_lo);
    assign any_hi    = |(src[2*WIDE_W-1:WIDE_W] & en_hi);
    assign any_basic = |(src[NSRC-1:2*WIDE_W] & en_basic);

    p_set_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && addr == REG_SET_LO) |=>
            ((en_lo & $past(wdata[WIDE_W-1:0])) == $past(wdata[WIDE_W-1:0]))
            && (($past(en_lo) & ~en_lo) == '0));

    p_clr_lo_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && addr == REG_CLR_LO) |=>
            ((en_lo & $past(wdata[WIDE_W-1:0])) == '0)
            && ((en_lo & ~$past(en_lo)) == '0));

    p_pend_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && we && addr <= 4'd2) |=>
            ($stable(en_lo) && $stable(en_hi) && $stable(en_basic)));

    p_req_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(any_lo || any_hi || any_basic)));

    p_req_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == valid);

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (num == '0));

    p_basic_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_basic |=> (valid && num >= NUM_W'(2 * WIDE_W)));

    p_lo_before_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_basic && any_lo) |=> (valid && num < NUM_W'(WIDE_W)));
endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
    .WIDE_W (WIDE_W),
    .BASIC_W(BASIC_W),
    .DATA_W (DATA_W),
    .NSRC   (NSRC),
    .NUM_W  (NUM_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     (irq_src_i),
    .sel     (bus_sel_i),
    .we      (bus_we_i),
    .addr    (bus_addr_i),
    .wdata   (bus_wdata_i),
    .en_lo   (en_lo),
    .en_hi   (en_hi),
    .en_basic(en_basic),
    .irq     (irq_o),
    .num     (irq_num_o),
    .valid   (irq_valid_o)
);

// File: tb/irq_bank_ctrl_bench.sv
module irq_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [71:0] src = '0;
    logic        sel = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic [6:0]  num;
    logic        valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit started = 1'b0;
    string rd_tag = "R11";

    logic [71:0] m_en = '0;
    logic [31:0] m_fast = '0;
    logic [31:0] e_rdata = '0;
    logic        e_irq = 1'b0;
    logic [6:0]  e_num = '0;
    logic        e_valid = 1'b0;
    string       e_tag = "R10";
    bit          was_reset = 1'b1;

    always #10 clk = ~clk;

    irq_bank_ctrl u_irq_bank_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_src_i  (src),
        .bus_sel_i  (sel),
        .bus_we_i   (we),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq),
        .irq_num_o  (num),
        .irq_valid_o(valid)
    );

    function automatic logic [31:0] model_read(input logic [3:0] a, input logic [71:0] p);
        logic [31:0] w;
        w = '0;
        case (a)
            4'd0: begin
                for (int k = 0; k < 8; k++) w[k] = p[64+k];
                w[8] = (p[31:0] != '0);
                w[9] = (p[63:32] != '0);
            end
            4'd1: w = p[31:0];
            4'd2: w = p[63:32];
            4'd3: w = m_fast;
            4'd4, 4'd7: w = m_en[31:0];
            4'd5, 4'd8: w = m_en[63:32];
            4'd6, 4'd9: w = {24'd0, m_en[71:64]};
            default: w = '0;
        endcase
        return w;
    endfunction

    // Reference model, advanced on every rising edge from the inputs of that cycle.
    always @(posedge clk) begin
        logic [71:0] p;
        int pick;
        started = 1'b1;
        if (!rst_n) begin
            m_en = '0; m_fast = '0; e_rdata = '0;
            e_irq = 1'b0; e_num = '0; e_valid = 1'b0;
            was_reset = 1'b1;
        end else begin
            was_reset = 1'b0;
            p = src & m_en;
            pick = -1;
            for (int n = 64; n < 72; n++) if (pick < 0 && p[n]) pick = n;
            for (int n = 0; n < 32; n++)  if (pick < 0 && p[n]) pick = n;
            for (int n = 32; n < 64; n++) if (pick < 0 && p[n]) pick = n;
            e_irq   = (p != '0);
            e_valid = (pick >= 0);
            e_num   = (pick >= 0) ? 7'(pick) : 7'd0;
            if (sel && !we) begin
                e_rdata = model_read(addr, p);
                e_tag   = rd_tag;
            end
            if (sel && we) begin
                for (int k = 0; k < 32; k++) begin
                    if (wdata[k]) begin
                        case (addr)
                            4'd4: m_en[k] = 1'b1;
                            4'd5: m_en[32+k] = 1'b1;
                            4'd6: if (k < 8) m_en[64+k] = 1'b1;
                            4'd7: m_en[k] = 1'b0;
                            4'd8: m_en[32+k] = 1'b0;
                            4'd9: if (k < 8) m_en[64+k] = 1'b0;
                            default: ;
                        endcase
                    end
                end
                if (addr == 4'd3) m_fast = wdata;
            end
        end
    end

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (rdata !== e_rdata) begin
                errors++;
                $display("FAIL %s rdata act=%h exp=%h", was_reset ? "R10" : e_tag, rdata, e_rdata);
            end
            checks++;
            if (irq !== e_irq) begin
                errors++;
                $display("FAIL %s irq act=%b exp=%b", was_reset ? "R10" : "R7", irq, e_irq);
            end
            checks++;
            if (valid !== e_valid) begin
                errors++;
                $display("FAIL %s valid act=%b exp=%b", was_reset ? "R10" : "R6", valid, e_valid);
            end
            checks++;
            if (num !== e_num) begin
                errors++;
                $display("FAIL %s num act=%0d exp=%0d", was_reset ? "R10" : "R5", num, e_num);
            end
        end
    end

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, input string tag);
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = a; rd_tag = tag;
        @(negedge clk);
        sel = 1'b0;
        @(negedge clk);
    endtask

    task automatic drive_src(input logic [71:0] v);
        @(negedge clk);
        src = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_rd(4'd3, "R9");                 // fast word resets to zero
        bus_rd(4'd4, "R10");                // enables reset to zero
        bus_wr(4'd4, 32'h0000_0011);        // R2 set bits 0 and 4
        bus_rd(4'd4, "R2");
        bus_wr(4'd4, 32'h0000_0100);        // R2 other bits kept
        bus_rd(4'd7, "R4");
        drive_src(72'h0_0000_0001_0000_0110); // R5 lowest in low bank: 4
        bus_rd(4'd1, "R1");
        bus_rd(4'd0, "R1");
        bus_wr(4'd5, 32'h8000_0001);        // R2 high bank
        bus_rd(4'd2, "R1");
        bus_wr(4'd7, 32'h0000_0011);        // R3 clear 0,4 -> serve 8
        bus_rd(4'd4, "R3");
        bus_wr(4'd7, 32'h0000_0100);        // R3 -> serve 32
        bus_rd(4'd0, "R1");
        bus_wr(4'd6, 32'hFFFF_FF44);        // R2 basic, upper bits dropped
        bus_rd(4'd9, "R4");
        drive_src(72'h44_0000_0001_0000_0100); // R5 basic 66 first
        bus_wr(4'd9, 32'h0000_0004);        // R3 -> basic 70
        bus_rd(4'd6, "R3");
        bus_wr(4'd0, 32'hFFFF_FFFF);        // R8
        bus_wr(4'd1, 32'hFFFF_FFFF);
        bus_wr(4'd2, 32'h0000_0000);
        bus_rd(4'd4, "R8");
        bus_rd(4'd5, "R8");
        bus_rd(4'd6, "R8");
        bus_wr(4'd3, 32'hA5A5_5A5A);        // R9
        bus_rd(4'd3, "R9");
        bus_wr(4'd13, 32'hFFFF_FFFF);       // R11 unmapped write
        bus_rd(4'd12, "R11");
        bus_rd(4'd5, "R11");
        drive_src('0);                      // R6 R7 all quiet
        drive_src(72'h00_8000_0000_0000_0000); // R5 high bank 63 alone
        bus_wr(4'd8, 32'h8000_0000);        // R7 falls after disable
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            src   = {$urandom, $urandom, $urandom};
            sel   = ($urandom_range(0, 2) != 0);
            we    = $urandom_range(0, 1) != 0;
            addr  = 4'($urandom_range(0, 15));
            wdata = $urandom;
            rd_tag = (addr <= 4'd2) ? "R1" : (addr == 4'd3) ? "R9" :
                     (addr <= 4'd9) ? "R4" : "R11";
        end
        @(negedge clk);
        sel = 1'b0;
        rst_n = 1'b0;                       // R10 reset mid-run
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_rd(4'd5, "R10");
        bus_rd(4'd3, "R10");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule